// File: doc/BRIEF.md
# I2C Master START Generator with Stuck-SDA Recovery

This block is the START-issuing stage of an I2C master. When a START is requested, it first releases both bus lines for one programmable half-period and then looks at SDA. If SDA is high, it pulls SDA low while SCL is high, holds that for one half-period, and then pulls SCL low. It keeps holding both lines low until the next request, so the byte engine that follows owns a bus in the post-START state. It then reports completion by loading status code 0x08 and raising an interrupt flag.

Another device, such as a slave that has lost bit synchronisation, may keep SDA low. In that case the block does not fail. It clocks SCL on its own, two pulses at a time, and samples SDA again after each pair. Once SDA is seen high, it issues a normal START. A request made while the block already holds the bus is a repeated START. It releases both lines and runs the same check-and-recover sequence. No software action is needed between the request and the interrupt.

The block only drives the lines low or releases them. Both sensed lines pass through a two-flop synchronizer. If another device holds SCL low, the block waits with SCL released. A parameterised limit on failed SDA checks sets a sticky timeout flag. The pulse train continues after the flag is set.

Top module: `i2c_start_recover`

## Requirements
- R1: After reset, sda_oe and scl_oe are 0 (both lines released), status is 0xF8, and irq and timeout are 0.
- R2: If a START is requested and SDA is seen high at the end of the first released half-period, the START is issued with no extra SCL pulses.
- R3: If SDA is seen low at that check, the block emits SCL pulses in pairs and repeats the check after each pair. The total pulse count is therefore the number of pulses during which SDA stayed low, rounded up to an even number.
- R4: Each recovery pulse drives SCL low (scl_oe = 1) for exactly half_period cycles, with sda_oe = 0 throughout. Each high phase is at least half_period cycles.
- R5: The START asserts sda_oe while scl_oe is 0 and SCL is high. scl_oe asserts exactly half_period cycles after sda_oe does.
- R6: When the START completes, status becomes 0x08 and irq becomes 1, and sda_oe and scl_oe both stay at 1 afterwards.
- R7: A request made while the bus is held (repeated START) releases both lines and follows the same check and recovery sequence as a request from the idle state.
- R8: If SCL is seen low at the end of a released phase, the block keeps SCL released and does not start the next pulse until SCL is seen high.
- R9: Once MAX_RETRY SDA checks have failed within one request, timeout becomes 1 and stays 1 until the next accepted request. Pulsing continues after the flag is set.
- R10: An accepted request clears irq and timeout and sets status to 0xF8 on the next cycle. A request made while a sequence is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | START request, sampled when the block is idle or holding the bus |
| half_period | input | HP_W | SCL half-period in clock cycles (values below 3 act as 3) |
| sda_in | input | 1 | Sensed SDA line level |
| scl_in | input | 1 | Sensed SCL line level |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| scl_oe | output | 1 | 1 = pull SCL low, 0 = release |
| status | output | 8 | 0xF8 while idle or busy, 0x08 once a START is done |
| irq | output | 1 | Interrupt flag, set when a START completes |
| timeout | output | 1 | Sticky flag, set after MAX_RETRY failed SDA checks |

## Verification
The bench holds SDA low for a chosen number of recovery pulses. It covers odd and even release points and a zero count, at several half-periods. A design that retried after every pulse, or that sampled SDA before the synchronizer caught up, would give a wrong pulse count.

It measures every SCL low phase and the SDA-to-SCL START spacing, which catches off-by-one half-period timers. It also holds SCL low in the middle of a pulse pair: a design that counted time instead of waiting would finish early or pulse against the held line.

It crosses the retry limit on consecutive requests and issues repeated STARTs. This exposes a timeout that misses its limit, fails to latch, or is not cleared by the next request. A request made in mid-sequence checks that a restart does not corrupt the pulse count.

// File: rtl/i2c_start_recover_pkg.sv
package i2c_start_recover_pkg;

    // Smallest usable half-period: covers the two-flop synchronizer delay.
    localparam int unsigned MIN_HALF = 3;

    localparam logic [7:0] STAT_NONE       = 8'hF8;
    localparam logic [7:0] STAT_START_DONE = 8'h08;

    typedef enum logic [2:0] {
        ST_IDLE,    // both lines released, no ownership
        ST_CHECK,   // lines released, SDA sampled at end of phase
        ST_LO,      // recovery pulse, SCL low
        ST_HI,      // recovery pulse, SCL released
        ST_START,   // SDA low with SCL high
        ST_HELD     // START issued, both lines held low
    } seq_state_t;

    typedef struct packed {
        logic sda;
        logic scl;
    } bus_lines_t;

    function automatic logic pulls_sda(input seq_state_t s);
        return (s == ST_START) || (s == ST_HELD);
    endfunction

    function automatic logic pulls_scl(input seq_state_t s);
        return (s == ST_LO) || (s == ST_HELD);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    // Idle bus lines read high, so the chain resets to ones.
    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '1;
        else     stage[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= '1;
            else     stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer
    import i2c_start_recover_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] half_period,
    output logic         done
);
    logic [W-1:0] cnt;
    logic [W-1:0] last;

    assign last = (half_period < W'(MIN_HALF)) ? W'(MIN_HALF - 1) : half_period - W'(1);
    assign done = (cnt >= last);

    // Saturates at the last count so a waiting phase keeps done high.
    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (!done)     cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/i2c_recover_seq.sv
module i2c_recover_seq
    import i2c_start_recover_pkg::*;
#(
    parameter int unsigned MAX_RETRY = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       sda_s,
    input  logic       scl_s,
    input  logic       phase_done,
    output logic       phase_restart,
    output logic       accept,
    output logic       sda_oe,
    output logic       scl_oe,
    output logic [7:0] status,
    output logic       irq,
    output logic       timeout
);
    seq_state_t state, nstate;
    logic       second_pulse;
    logic       check_fail;
    logic       start_done;

    assign accept     = ((state == ST_IDLE) || (state == ST_HELD)) && start_req;
    assign check_fail = (state == ST_CHECK) && phase_done && scl_s && !sda_s;
    assign start_done = (state == ST_START) && phase_done;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE, ST_HELD: if (start_req) nstate = ST_CHECK;
            ST_CHECK: if (phase_done && scl_s) nstate = sda_s ? ST_START : ST_LO;
            ST_LO:    if (phase_done) nstate = second_pulse ? ST_CHECK : ST_HI;
            ST_HI:    if (phase_done && scl_s) nstate = ST_LO;
            ST_START: if (phase_done) nstate = ST_HELD;
            default:  nstate = ST_IDLE;
        endcase
    end

    assign phase_restart = (nstate != state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            second_pulse <= 1'b0;
        end else begin
            state <= nstate;
            if (check_fail)
                second_pulse <= 1'b0;
            else if (state == ST_LO && phase_done)
                second_pulse <= !second_pulse;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || accept) begin
            status <= STAT_NONE;
            irq    <= 1'b0;
        end else if (start_done) begin
            status <= STAT_START_DONE;
            irq    <= 1'b1;
        end
    end

    assign sda_oe = pulls_sda(state);
    assign scl_oe = pulls_scl(state);

    if (MAX_RETRY > 0) begin : g_limit
        localparam int unsigned RW = $clog2(MAX_RETRY + 1);
        logic [RW-1:0] fails;
        logic          to_r;
        always_ff @(posedge clk) begin
            if (rst || accept) begin
                fails <= '0;
                to_r  <= 1'b0;
            end else if (check_fail) begin
                if (fails != RW'(MAX_RETRY)) fails <= fails + RW'(1);
                if (int'(fails) + 1 >= int'(MAX_RETRY)) to_r <= 1'b1;
            end
        end
        assign timeout = to_r;
    end else begin : g_nolimit
        assign timeout = 1'b0;
    end
endmodule

// File: rtl/i2c_start_recover.sv
module i2c_start_recover
    import i2c_start_recover_pkg::*;
#(
    parameter int unsigned HP_W      = 8,
    parameter int unsigned MAX_RETRY = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_req,
    input  logic [HP_W-1:0] half_period,
    input  logic            sda_in,
    input  logic            scl_in,
    output logic            sda_oe,
    output logic            scl_oe,
    output logic [7:0]      status,
    output logic            irq,
    output logic            timeout
);
    bus_lines_t raw_lines, seen_lines;
    logic       sda_s, scl_s;
    logic       phase_done, phase_restart, accept;

    assign raw_lines = '{sda: sda_in, scl: scl_in};

    i2c_line_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (seen_lines)
    );

    assign sda_s = seen_lines.sda;
    assign scl_s = seen_lines.scl;

    i2c_phase_timer #(.W(HP_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .restart     (phase_restart),
        .half_period (half_period),
        .done        (phase_done)
    );

    i2c_recover_seq #(.MAX_RETRY(MAX_RETRY)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_req     (start_req),
        .sda_s         (sda_s),
        .scl_s         (scl_s),
        .phase_done    (phase_done),
        .phase_restart (phase_restart),
        .accept        (accept),
        .sda_oe        (sda_oe),
        .scl_oe        (scl_oe),
        .status        (status),
        .irq           (irq),
        .timeout       (timeout)
    );
endmodule

// File: rtl/i2c_start_recover_chk.sv
module i2c_start_recover_chk (
    input logic       clk,
    input logic       rst,
    input logic       sda_oe,
    input logic       scl_oe,
    input logic [7:0] status,
    input logic       irq,
    input logic       timeout,
    input logic       scl_seen,
    input logic       accept
);
    AST_START_UNDER_HIGH_SCL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> (!scl_oe && $past(scl_seen))); // R5

    AST_PULSE_WAITS_FOR_SCL: assert property (@(posedge clk) disable iff (rst)
        ($rose(scl_oe) && !sda_oe) |-> $past(scl_seen)); // R8

    AST_DONE_REPORTS_08: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (status == 8'h08 && sda_oe && scl_oe)); // R6

    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(timeout) && !$past(accept)) |-> timeout); // R9

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!irq && !timeout && status == 8'hF8)); // R10
endmodule

bind i2c_start_recover i2c_start_recover_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe),
    .status   (status),
    .irq      (irq),
    .timeout  (timeout),
    .scl_seen (scl_s),
    .accept   (accept)
);

// File: tb/i2c_start_recover_test.sv
module i2c_start_recover_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_req;
    logic [7:0] half_period;
    logic       sda_oe, scl_oe, irq, timeout;
    logic [7:0] status;
    logic       tb_sda_low;
    logic       tb_scl_low;
    logic       sda_line, scl_line;

    assign sda_line = !(sda_oe || tb_sda_low);
    assign scl_line = !(scl_oe || tb_scl_low);

    always #2.5 clk = !clk;

    i2c_start_recover #(.HP_W(8), .MAX_RETRY(4)) uut (
        .clk(clk), .rst(rst), .start_req(start_req), .half_period(half_period),
        .sda_in(sda_line), .scl_in(scl_line), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .status(status), .irq(irq), .timeout(timeout)
    );

    // {half_period[31:24], sda-low pulses[23:16], expected pulses[15:8], timeout[7:4], mid-run request[3:0]}
    localparam logic [31:0] VEC [6] = '{
        32'h0400_0000,
        32'h0401_0200,
        32'h0302_0200,
        32'h0505_0601,
        32'h0608_0810,
        32'h0309_0A10
    };

    int n_chk = 0;
    int n_fail = 0;
    int arm_id = 0;
    int k_cur = 0;
    int hp_cur = 4;

    // Bus monitor: counts pulses, releases SDA after k_cur pulses, times phases.
    int  seen_id = 0;
    int  pulse_cnt = 0;
    int  lo_run = 0, st_run = 0, lo_err = 0, st_err = 0;
    logic lo_prev = 1'b0, st_prev = 1'b0;

    initial tb_sda_low = 1'b0;

    always @(negedge clk) begin
        if (arm_id != seen_id) begin
            seen_id = arm_id;
            pulse_cnt = 0; lo_err = 0; st_err = 0;
            tb_sda_low = (k_cur != 0);
        end
        if (!rst) begin
            if (scl_oe && !sda_oe && !lo_prev) begin
                pulse_cnt++;
                if (pulse_cnt == k_cur) tb_sda_low = 1'b0;
            end
            if (scl_oe && !sda_oe) lo_run++;
            else begin
                if (lo_run != 0 && lo_run != hp_cur) lo_err++;
                lo_run = 0;
            end
            if (sda_oe && !scl_oe && !st_prev && !scl_line) st_err++;
            if (sda_oe && !scl_oe) st_run++;
            else begin
                if (st_run != 0 && st_run != hp_cur) st_err++;
                st_run = 0;
            end
            lo_prev = scl_oe && !sda_oe;
            st_prev = sda_oe && !scl_oe;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic request(input int hp, input int k, input string req);
        @(negedge clk);
        half_period = 8'(hp);
        hp_cur = hp;
        k_cur = k;
        arm_id++;
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check(irq == 1'b0, {req, " irq cleared on accept (R10)"}, int'(irq), 0);
        check(status == 8'hF8, {req, " status F8 on accept (R10)"}, int'(status), 248);
        check(timeout == 1'b0, {req, " timeout cleared (R10)"}, int'(timeout), 0);
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(irq == 1'b1, {req, " irq after START (R6)"}, int'(irq), 1);
        check(status == 8'h08, {req, " status 08 (R6)"}, int'(status), 8);
        check(sda_oe && scl_oe, {req, " lines held low after START (R6)"},
              int'({sda_oe, scl_oe}), 3);
    endtask

    task automatic run_tests;
        rst = 1'b1; start_req = 1'b0; half_period = 8'd4; tb_scl_low = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!sda_oe && !scl_oe, "R1 lines released", int'({sda_oe, scl_oe}), 0);
        check(status == 8'hF8, "R1 status", int'(status), 248);
        check(!irq && !timeout, "R1 irq/timeout", int'({irq, timeout}), 0);

        for (int i = 0; i < 6; i++) begin
            logic [31:0] v;
            string tag;
            v = VEC[i];
            tag = (i == 0) ? "R2" : "R3/R7";
            request(int'(v[31:24]), int'(v[23:16]), tag);
            if (v[3:0] != 0) begin
                while (pulse_cnt < 1) @(negedge clk);
                start_req = 1'b1;
                @(negedge clk);
                start_req = 1'b0;
            end
            wait_irq(tag);
            check(pulse_cnt == int'(v[15:8]), {tag, " recovery pulse count"},
                  pulse_cnt, int'(v[15:8]));
            if (v[3:0] != 0)
                check(pulse_cnt == int'(v[15:8]), "R10 mid-run request ignored",
                      pulse_cnt, int'(v[15:8]));
            check(lo_err == 0, "R4 SCL low phase length", lo_err, 0);
            check(st_err == 0, "R5 START shape and spacing", st_err, 0);
            check(timeout == v[4], "R9 timeout flag", int'(timeout), int'(v[4]));
        end

        // R8: SCL held low by another device in the middle of a pulse pair.
        request(4, 3, "R8");
        while (!(pulse_cnt == 1 && !scl_oe)) @(negedge clk);
        tb_scl_low = 1'b1;
        repeat (40) @(negedge clk);
        check(pulse_cnt == 1, "R8 no pulse while SCL held", pulse_cnt, 1);
        check(scl_oe == 1'b0, "R8 SCL stays released", int'(scl_oe), 0);
        check(irq == 1'b0, "R8 no completion while SCL held", int'(irq), 0);
        tb_scl_low = 1'b0;
        wait_irq("R8");
        check(pulse_cnt == 4, "R8 pulse count after wait", pulse_cnt, 4);
        check(lo_err == 0, "R8 low phases intact", lo_err, 0);
    endtask

    initial begin
        logic hung;
        hung = 1'b0;
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                hung = 1'b1;
            end
        join_any
        disable fork;
        if (hung) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule